// File: doc/BRIEF.md
# Banked Nibble Register File with Pair Access

This block holds the general registers of a small 4-bit processor core. Storage is four banks of eight 4-bit registers, named A, X, L, H, E, D, C and B. A core reaches them in three ways: one nibble at a time, as 8-bit register pairs, or as plain data memory. A pair joins an even register (the low nibble) with the odd register just above it (the high nibble). Each pair access can also be sent to a partner bank to reach a second, primed set of pairs.

The working bank comes from a bank-enable flag and a 2-bit bank select. With the flag clear, bank 0 is always used. With the flag set, the select value names the bank. The primed pairs come from the bank whose number differs from the working bank only in its lowest bit. This gives software eight reachable 8-bit registers.

The same 32 cells also appear at data addresses 00H to 1FH through a memory-style port, so that ordinary memory reads and writes reach the registers directly. Reads are combinational from the stored cells. Writes take effect at the rising clock edge.

Top module: `gpr_bank_file`

## Requirements
- R1: After reset, all 32 cells read as zero through every read port.
- R2: The working bank is bank_sel when bank_en is 1, and bank 0 when bank_en is 0, whatever bank_sel holds.
- R3: Register index encoding is A=0, X=1, L=2, H=3, E=4, D=5, C=6, B=7. A nibble access reaches data address 8*bank + index.
- R4: Pair index encoding is XA=0, HL=1, DE=2, BC=3. Pair p uses offset 2p as its low nibble (bits 3:0) and offset 2p+1 as its high nibble (bits 7:4).
- R5: With pair_alt=1, a pair access (read or write) uses bank (working bank XOR 1) instead of the working bank.
- R6: The memory port at address a (0 to 31) reads and writes the same cell that bank a/8, offset a%8 names on the register ports.
- R7: All three read outputs are combinational from the stored cells. A write is visible on the read ports in the cycle after its clock edge.
- R8: When a register-port write (nibble or pair) and a memory-port write target the same cell in one cycle, the register-port data is stored. A memory write to a different cell in that cycle still takes effect.
- R9: When a nibble write and a pair write target the same cell in one cycle, the nibble data is stored in that cell. The other nibble of the pair is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_en | input | 1 | Bank-enable flag |
| bank_sel | input | 2 | Bank select value |
| nib_idx | input | 3 | Register index for nibble read and write |
| nib_wr_en | input | 1 | Nibble write enable |
| nib_wr_data | input | 4 | Nibble write data |
| nib_rd_data | output | 4 | Nibble read data |
| pair_idx | input | 2 | Pair index |
| pair_alt | input | 1 | Select the primed (partner-bank) pair |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wr_data | input | 8 | Pair write data, high nibble in bits 7:4 |
| pair_rd_data | output | 8 | Pair read data |
| mem_addr | input | 5 | Memory-view data address |
| mem_wr_en | input | 1 | Memory-view write enable |
| mem_wr_data | input | 4 | Memory-view write data |
| mem_rd_data | output | 4 | Memory-view read data |

## Verification
Read results have zero latency: the nibble, pair and memory outputs follow their address inputs within the same cycle. A write lands at the next rising edge and can be seen from the cycle after it. The bench therefore drives each cycle's inputs just after the falling edge and compares all three read outputs shortly afterwards against a reference array. That array holds the state before the coming edge. The bench updates the array at the rising edge using the write priorities of R8 and R9, so every write is checked one cycle after it is issued, from whichever port reads it back.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [2:0] {
    REG_A = 3'd0,
    REG_X = 3'd1,
    REG_L = 3'd2,
    REG_H = 3'd3,
    REG_E = 3'd4,
    REG_D = 3'd5,
    REG_C = 3'd6,
    REG_B = 3'd7
  } gpr_name_e;

  typedef enum logic [1:0] {
    PAIR_XA = 2'd0,
    PAIR_HL = 2'd1,
    PAIR_DE = 2'd2,
    PAIR_BC = 2'd3
  } gpr_pair_e;

  // working bank: select value gated by the enable flag
  function automatic int unsigned gated_bank(input logic en, input int unsigned sel);
    return en ? sel : 0;
  endfunction

  // partner bank for primed pairs: flip bit 0 only
  function automatic int unsigned partner_bank(input int unsigned bank);
    return bank ^ 1;
  endfunction

endpackage

// File: rtl/gpr_bank_decode.sv
module gpr_bank_decode #(
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3,
  parameter int PAIR_W = IDX_W - 1,
  parameter int ADDR_W = BANK_W + IDX_W
) (
  input  logic              bank_en,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [IDX_W-1:0]  nib_idx,
  input  logic [PAIR_W-1:0] pair_idx,
  input  logic              pair_alt,
  output logic [BANK_W-1:0] act_bank,
  output logic [BANK_W-1:0] pair_bank,
  output logic [ADDR_W-1:0] nib_addr,
  output logic [ADDR_W-1:0] pair_lo_addr,
  output logic [ADDR_W-1:0] pair_hi_addr
);

  assign act_bank     = bank_sel & {BANK_W{bank_en}};
  assign pair_bank    = act_bank ^ BANK_W'(pair_alt);
  assign nib_addr     = {act_bank, nib_idx};
  assign pair_lo_addr = {pair_bank, pair_idx, 1'b0};
  assign pair_hi_addr = {pair_bank, pair_idx, 1'b1};

endmodule

// File: rtl/gpr_cell_array.sv
module gpr_cell_array #(
  parameter int CELLS  = 32,
  parameter int NIB_W  = 4,
  parameter int ADDR_W = $clog2(CELLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nib_we,
  input  logic [ADDR_W-1:0]    nib_addr,
  input  logic [NIB_W-1:0]     nib_wdata,
  input  logic                 pair_we,
  input  logic [ADDR_W-1:0]    pair_lo_addr,
  input  logic [ADDR_W-1:0]    pair_hi_addr,
  input  logic [2*NIB_W-1:0]   pair_wdata,
  input  logic                 mem_we,
  input  logic [ADDR_W-1:0]    mem_addr,
  input  logic [NIB_W-1:0]     mem_wdata,
  output logic [NIB_W-1:0]     nib_rdata,
  output logic [2*NIB_W-1:0]   pair_rdata,
  output logic [NIB_W-1:0]     mem_rdata,
  output logic                 mem_wr_blocked
);

  logic [CELLS-1:0][NIB_W-1:0] cell_flat;
  logic [CELLS-1:0]            reg_hit;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic [NIB_W-1:0] q;
    logic hit_nib, hit_phi, hit_plo, hit_mem;

    assign hit_nib = nib_we  && (nib_addr     == ADDR_W'(c));
    assign hit_phi = pair_we && (pair_hi_addr == ADDR_W'(c));
    assign hit_plo = pair_we && (pair_lo_addr == ADDR_W'(c));
    assign hit_mem = mem_we  && (mem_addr     == ADDR_W'(c));
    assign reg_hit[c] = hit_nib | hit_phi | hit_plo;

    // priority: nibble port, then pair port, then memory view
    always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (hit_nib) q <= nib_wdata;
      else if (hit_phi) q <= pair_wdata[2*NIB_W-1:NIB_W];
      else if (hit_plo) q <= pair_wdata[NIB_W-1:0];
      else if (hit_mem) q <= mem_wdata;
    end

    assign cell_flat[c] = q;
  end

  assign nib_rdata      = cell_flat[nib_addr];
  assign pair_rdata     = {cell_flat[pair_hi_addr], cell_flat[pair_lo_addr]};
  assign mem_rdata      = cell_flat[mem_addr];
  assign mem_wr_blocked = mem_we && reg_hit[mem_addr];

endmodule

// File: rtl/gpr_bank_file.sv
module gpr_bank_file #(
  parameter int NUM_BANKS     = 4,
  parameter int REGS_PER_BANK = 8,
  parameter int NIB_W         = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bank_en,
  input  logic [$clog2(NUM_BANKS)-1:0]       bank_sel,
  input  logic [$clog2(REGS_PER_BANK)-1:0]   nib_idx,
  input  logic                               nib_wr_en,
  input  logic [NIB_W-1:0]                   nib_wr_data,
  output logic [NIB_W-1:0]                   nib_rd_data,
  input  logic [$clog2(REGS_PER_BANK)-2:0]   pair_idx,
  input  logic                               pair_alt,
  input  logic                               pair_wr_en,
  input  logic [2*NIB_W-1:0]                 pair_wr_data,
  output logic [2*NIB_W-1:0]                 pair_rd_data,
  input  logic [$clog2(NUM_BANKS*REGS_PER_BANK)-1:0] mem_addr,
  input  logic                               mem_wr_en,
  input  logic [NIB_W-1:0]                   mem_wr_data,
  output logic [NIB_W-1:0]                   mem_rd_data
);

  localparam int CELLS  = NUM_BANKS * REGS_PER_BANK;
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = $clog2(REGS_PER_BANK);
  localparam int PAIR_W = IDX_W - 1;
  localparam int ADDR_W = BANK_W + IDX_W;

  logic [BANK_W-1:0] act_bank;
  logic [BANK_W-1:0] pair_bank;
  logic [ADDR_W-1:0] nib_addr;
  logic [ADDR_W-1:0] pair_lo_addr;
  logic [ADDR_W-1:0] pair_hi_addr;
  logic              mem_wr_blocked;

  gpr_bank_decode #(
    .BANK_W (BANK_W),
    .IDX_W  (IDX_W),
    .PAIR_W (PAIR_W),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .bank_en      (bank_en),
    .bank_sel     (bank_sel),
    .nib_idx      (nib_idx),
    .pair_idx     (pair_idx),
    .pair_alt     (pair_alt),
    .act_bank     (act_bank),
    .pair_bank    (pair_bank),
    .nib_addr     (nib_addr),
    .pair_lo_addr (pair_lo_addr),
    .pair_hi_addr (pair_hi_addr)
  );

  gpr_cell_array #(
    .CELLS  (CELLS),
    .NIB_W  (NIB_W),
    .ADDR_W (ADDR_W)
  ) u_cells (
    .clk            (clk),
    .rst_n          (rst_n),
    .nib_we         (nib_wr_en),
    .nib_addr       (nib_addr),
    .nib_wdata      (nib_wr_data),
    .pair_we        (pair_wr_en),
    .pair_lo_addr   (pair_lo_addr),
    .pair_hi_addr   (pair_hi_addr),
    .pair_wdata     (pair_wr_data),
    .mem_we         (mem_wr_en),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wr_data),
    .nib_rdata      (nib_rd_data),
    .pair_rdata     (pair_rd_data),
    .mem_rdata      (mem_rd_data),
    .mem_wr_blocked (mem_wr_blocked)
  );

endmodule

// File: rtl/gpr_bank_file_chk.sv
module gpr_bank_file_chk #(
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               nib_wr_en,
  input logic [NIB_W-1:0]   nib_wr_data,
  input logic [NIB_W-1:0]   nib_rd_data,
  input logic               pair_wr_en,
  input logic [2*NIB_W-1:0] pair_wr_data,
  input logic [2*NIB_W-1:0] pair_rd_data,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               mem_wr_en,
  input logic [NIB_W-1:0]   mem_wr_data,
  input logic [NIB_W-1:0]   mem_rd_data,
  input logic [ADDR_W-1:0]  nib_addr,
  input logic [ADDR_W-1:0]  pair_lo_addr,
  input logic [ADDR_W-1:0]  pair_hi_addr,
  input logic               mem_wr_blocked
);

  // R6
  nib_mem_view_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr == nib_addr) |-> (mem_rd_data == nib_rd_data));

  // R4
  pair_mem_view_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr == pair_hi_addr) |-> (mem_rd_data == pair_rd_data[2*NIB_W-1:NIB_W]));

  // R7
  mem_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !nib_wr_en && !pair_wr_en) |=>
      ((mem_addr != $past(mem_addr)) || (mem_rd_data == $past(mem_wr_data))));

  // R8
  reg_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && nib_wr_en && !pair_wr_en && (mem_addr == nib_addr)) |=>
      ((mem_addr != $past(mem_addr)) || (mem_rd_data == $past(nib_wr_data))));

  // R8
  blocked_only_on_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !nib_wr_en && !pair_wr_en) |-> !mem_wr_blocked);

  // R7
  pair_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_wr_en && !nib_wr_en && !mem_wr_en) |=>
      ((pair_lo_addr != $past(pair_lo_addr)) || (pair_rd_data == $past(pair_wr_data))));

endmodule

bind gpr_bank_file gpr_bank_file_chk #(
  .NIB_W  (NIB_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .nib_wr_en      (nib_wr_en),
  .nib_wr_data    (nib_wr_data),
  .nib_rd_data    (nib_rd_data),
  .pair_wr_en     (pair_wr_en),
  .pair_wr_data   (pair_wr_data),
  .pair_rd_data   (pair_rd_data),
  .mem_addr       (mem_addr),
  .mem_wr_en      (mem_wr_en),
  .mem_wr_data    (mem_wr_data),
  .mem_rd_data    (mem_rd_data),
  .nib_addr       (nib_addr),
  .pair_lo_addr   (pair_lo_addr),
  .pair_hi_addr   (pair_hi_addr),
  .mem_wr_blocked (mem_wr_blocked)
);

// File: tb/gpr_bank_file_tb.sv
`timescale 1ns/1ps
module gpr_bank_file_tb_top;
  import gpr_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_en = 1'b0;
  logic [1:0] bank_sel = '0;
  logic [2:0] nib_idx = '0;
  logic       nib_wr_en = 1'b0;
  logic [3:0] nib_wr_data = '0;
  logic [3:0] nib_rd_data;
  logic [1:0] pair_idx = '0;
  logic       pair_alt = 1'b0;
  logic       pair_wr_en = 1'b0;
  logic [7:0] pair_wr_data = '0;
  logic [7:0] pair_rd_data;
  logic [4:0] mem_addr = '0;
  logic       mem_wr_en = 1'b0;
  logic [3:0] mem_wr_data = '0;
  logic [3:0] mem_rd_data;

  int checks = 0;
  int failures = 0;
  logic [3:0] model [32];

  always #4 clk = ~clk;

  gpr_bank_file dut_i (
    .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .bank_sel(bank_sel),
    .nib_idx(nib_idx), .nib_wr_en(nib_wr_en), .nib_wr_data(nib_wr_data),
    .nib_rd_data(nib_rd_data), .pair_idx(pair_idx), .pair_alt(pair_alt),
    .pair_wr_en(pair_wr_en), .pair_wr_data(pair_wr_data),
    .pair_rd_data(pair_rd_data), .mem_addr(mem_addr), .mem_wr_en(mem_wr_en),
    .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data)
  );

  function automatic int exp_nib_addr(input logic en, input logic [1:0] sel, input logic [2:0] idx);
    return gated_bank(en, int'(sel)) * 8 + int'(idx);
  endfunction

  function automatic int exp_pair_lo(input logic en, input logic [1:0] sel,
                                     input logic [1:0] p, input logic alt);
    int unsigned b;
    b = gated_bank(en, int'(sel));
    if (alt) b = partner_bank(b);
    return int'(b) * 8 + 2 * int'(p);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic en, input logic [1:0] sel,
                      input logic [2:0] ni, input logic nwe, input logic [3:0] nd,
                      input logic [1:0] pi, input logic alt, input logic pwe,
                      input logic [7:0] pd, input logic [4:0] ma, input logic mwe,
                      input logic [3:0] md);
    int na, pl;
    @(negedge clk);
    bank_en = en; bank_sel = sel; nib_idx = ni; nib_wr_en = nwe; nib_wr_data = nd;
    pair_idx = pi; pair_alt = alt; pair_wr_en = pwe; pair_wr_data = pd;
    mem_addr = ma; mem_wr_en = mwe; mem_wr_data = md;
    na = exp_nib_addr(en, sel, ni);
    pl = exp_pair_lo(en, sel, pi, alt);
    #1;
    chk(tag, "nib_rd",  int'(nib_rd_data),  int'(model[na]));
    chk(tag, "pair_rd", int'(pair_rd_data), int'({model[pl+1], model[pl]}));
    chk(tag, "mem_rd",  int'(mem_rd_data),  int'(model[ma]));
    @(posedge clk);
    if (mwe) model[ma] = md;
    if (pwe) begin model[pl] = pd[3:0]; model[pl+1] = pd[7:4]; end
    if (nwe) model[na] = nd;
  endtask

  task automatic rd_mem(input string tag, input logic [4:0] a);
    step(tag, 1'b0, 2'd0, 3'd0, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, 8'h00, a, 1'b0, 4'h0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) model[i] = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every cell zero after reset
    for (int a = 0; a < 32; a++) rd_mem("R1", 5'(a));

    // R2: enable clear forces bank 0 even with select 2
    step("R2", 1'b0, 2'd2, REG_H, 1'b1, 4'h5, PAIR_XA, 1'b0, 1'b0, 8'h00, 5'd0, 1'b0, 4'h0);
    rd_mem("R2", 5'd3);
    rd_mem("R2", 5'd19);

    // R3: register B of bank 2 sits at address 23
    step("R3", 1'b1, 2'd2, REG_B, 1'b1, 4'hA, PAIR_XA, 1'b0, 1'b0, 8'h00, 5'd0, 1'b0, 4'h0);
    rd_mem("R3", 5'd23);

    // R4: HL of bank 2 -> L at 18, H at 19
    step("R4", 1'b1, 2'd2, REG_A, 1'b0, 4'h0, PAIR_HL, 1'b0, 1'b1, 8'h3C, 5'd0, 1'b0, 4'h0);
    rd_mem("R4", 5'd18);
    rd_mem("R4", 5'd19);
    step("R4", 1'b1, 2'd2, REG_L, 1'b0, 4'h0, PAIR_HL, 1'b0, 1'b0, 8'h00, 5'd18, 1'b0, 4'h0);

    // R5: primed DE from bank 2 goes to bank 3; primed from bank 3 reads bank 2
    step("R5", 1'b1, 2'd2, REG_A, 1'b0, 4'h0, PAIR_DE, 1'b1, 1'b1, 8'h96, 5'd0, 1'b0, 4'h0);
    rd_mem("R5", 5'd28);
    rd_mem("R5", 5'd29);
    step("R5", 1'b1, 2'd3, REG_A, 1'b0, 4'h0, PAIR_HL, 1'b1, 1'b0, 8'h00, 5'd20, 1'b0, 4'h0);

    // R6: memory write at 9 is register X of bank 1
    step("R6", 1'b0, 2'd0, REG_A, 1'b0, 4'h0, PAIR_XA, 1'b0, 1'b0, 8'h00, 5'd9, 1'b1, 4'h7);
    step("R6", 1'b1, 2'd1, REG_X, 1'b0, 4'h0, PAIR_XA, 1'b0, 1'b0, 8'h00, 5'd9, 1'b0, 4'h0);

    // R8: collision on cell 12 (bank1 E) and a non-colliding pair
    step("R8", 1'b1, 2'd1, REG_E, 1'b1, 4'h2, PAIR_XA, 1'b0, 1'b0, 8'h00, 5'd12, 1'b1, 4'hF);
    rd_mem("R8", 5'd12);
    step("R8", 1'b1, 2'd1, REG_C, 1'b1, 4'h4, PAIR_XA, 1'b0, 1'b0, 8'h00, 5'd30, 1'b1, 4'hB);
    rd_mem("R8", 5'd14);
    rd_mem("R8", 5'd30);
    step("R8", 1'b1, 2'd0, REG_A, 1'b0, 4'h0, PAIR_BC, 1'b0, 1'b1, 8'hE1, 5'd7, 1'b1, 4'h9);
    rd_mem("R8", 5'd7);

    // R9: nibble H and pair HL of bank 0 in one cycle
    step("R9", 1'b1, 2'd0, REG_H, 1'b1, 4'hD, PAIR_HL, 1'b0, 1'b1, 8'h58, 5'd0, 1'b0, 4'h0);
    rd_mem("R9", 5'd3);
    rd_mem("R9", 5'd2);

    // R7: random mix, all read ports compared every cycle
    for (int n = 0; n < 400; n++) begin
      step("R7", 1'($urandom), 2'($urandom), 3'($urandom), 1'($urandom), 4'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
           5'($urandom), 1'($urandom), 4'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule